// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block sits between a UART receiver and its receive FIFO and watches every received character for software flow-control codes. Four character registers hold the resume and halt codes, first and second character of each. In single mode one character is enough for a match. In double mode two consecutive characters must form the sequence. A halt code suspends the transmitter, and a resume code lets it run again. The matched codes are taken out of the stream, and every other character is passed on to the FIFO side.

Suspension takes effect at a character boundary. The block is told whether the transmitter is busy shifting a character, and it withdraws its permission only while the transmitter is idle, so a character in flight always completes. A sticky flow-control flag records a halt. It can be masked, and it drives an interrupt request when the receive interrupt is enabled.

In double mode a candidate first character is held back until the next character arrives. If that character does not complete the sequence, both characters are released in arrival order on two consecutive cycles. Received-character strobes must therefore be at least two cycles apart, which a UART receiver meets by a wide margin.

Top module: `xfc_top`

## Requirements
- R1: After reset all four character registers read as 0x00. A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_sel`: 0 = resume first, 1 = resume second, 2 = halt first, 3 = halt second.
- R2: With `fc_en`=1 and `pair_mode`=0, a character equal to halt-first is dropped and suspends the transmitter. A character equal to resume-first is dropped and releases the suspension. When both registers hold the same code, the halt action wins.
- R3: A character that is not consumed as a flow-control code appears on `fwd_valid`/`fwd_data` for exactly one cycle, right after the clock edge that sampled its `rx_valid` strobe. This also applies while the transmitter is suspended.
- R4: With `pair_mode`=1, halt-first followed by halt-second on the next strobe suspends the transmitter and drops both characters. Resume-first followed by resume-second releases the suspension and drops both characters.
- R5: With `pair_mode`=1, if a held first character is followed by a character that does not complete its sequence, the held character is forwarded on the cycle after the second strobe and the second character on the cycle after that.
- R6: `tx_allow` is 1 whenever `tx_busy` is 1. While suspended it drops to 0 in the same cycle that `tx_busy` falls.
- R7: A halt match sets `fc_flag` only when `flag_en`=1. A resume match clears `fc_flag`.
- R8: `irq` equals `fc_flag` gated by `rx_irq_en`.
- R9: Setting `fc_en`=0 releases any suspension and clears `fc_flag` one edge later. It also forwards a held first character on the next cycle. While `fc_en`=0, every character passes unchanged.
- R10: A resume match while not suspended is still dropped and leaves `tx_allow` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Character register write strobe |
| cfg_sel | input | 2 | Register select (0 resume-1st, 1 resume-2nd, 2 halt-1st, 3 halt-2nd) |
| cfg_wdata | input | CHAR_W | Character register write data |
| fc_en | input | 1 | Software flow control enable |
| pair_mode | input | 1 | 0 = single-character codes, 1 = two-character codes |
| flag_en | input | 1 | Allows a halt match to set the flag |
| rx_irq_en | input | 1 | Receive interrupt enable, gates `irq` |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | CHAR_W | Received character |
| tx_busy | input | 1 | Transmitter is shifting a character |
| fwd_valid | output | 1 | Character forwarded to the receive FIFO |
| fwd_data | output | CHAR_W | Forwarded character |
| tx_allow | output | 1 | Transmitter may start a new character |
| fc_flag | output | 1 | Flow-control status flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a double-mode first character that is still held when the controller is disabled. Here the flush must release the held character on the very next cycle, and no later strobe may be mixed in with it. The bench sends only the first half of a halt sequence. It then drops `fc_en` between strobes and samples the forward port on the single cycle that follows. A mismatched second character is handled the same way: both release cycles are sampled back to back to confirm the arrival order.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_XON  = 2'd1,
    EV_XOFF = 2'd2
  } fc_evt_e;

  localparam int unsigned NREF      = 4;
  localparam int unsigned SEL_W     = $clog2(NREF);
  localparam int unsigned IDX_ON_A  = 0;
  localparam int unsigned IDX_ON_B  = 1;
  localparam int unsigned IDX_OFF_A = 2;
  localparam int unsigned IDX_OFF_B = 3;
endpackage

// File: rtl/xfc_chregs.sv
module xfc_chregs
  import xfc_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SEL_W-1:0]         sel,
  input  logic [CW-1:0]            wdata,
  output logic [NREF-1:0][CW-1:0]  refs
);
  for (genvar i = 0; i < NREF; i++) begin : g_reg
    logic          wr_en;
    logic [CW-1:0] q;
    assign wr_en = we && (sel == SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wdata;
    end
    assign refs[i] = q;
  end
endmodule

// File: rtl/xfc_cmp.sv
module xfc_cmp
  import xfc_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic [CW-1:0]            ch,
  input  logic [NREF-1:0][CW-1:0]  refs,
  output logic [NREF-1:0]          hits
);
  for (genvar i = 0; i < NREF; i++) begin : g_cmp
    assign hits[i] = (ch == refs[i]);
  end
endmodule

// File: rtl/xfc_seq.sv
module xfc_seq
  import xfc_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pair,
  input  logic             rx_v,
  input  logic [CW-1:0]    rx_d,
  input  logic [NREF-1:0]  hits,
  output logic             fwd_v,
  output logic [CW-1:0]    fwd_d,
  output fc_evt_e          evt
);
  localparam int unsigned NCAND = 3;

  logic          hold_q, hold_n;
  logic [CW-1:0] held_d_q, held_d_n;
  logic          held_on_q, held_on_n, held_off_q, held_off_n;
  logic          fwd_v_q, pend_v_q;
  logic [CW-1:0] fwd_d_q, pend_d_q;

  logic                      e_held, e_rx;
  logic [NCAND-1:0]          cand_v;
  logic [NCAND-1:0][CW-1:0]  cand_d;
  logic [1:0]                s_v;
  logic [1:0][CW-1:0]        s_d;
  logic [1:0]                n_emit;

  // next-state: match sequencing
  always_comb begin
    hold_n     = hold_q;
    held_d_n   = held_d_q;
    held_on_n  = held_on_q;
    held_off_n = held_off_q;
    evt        = EV_NONE;
    e_held     = 1'b0;
    e_rx       = 1'b0;
    if (hold_q && (!en || !pair)) begin
      e_held = 1'b1;
      hold_n = 1'b0;
    end
    if (rx_v) begin
      if (!en) begin
        e_rx = 1'b1;
      end else if (!pair) begin
        if (hits[IDX_OFF_A])     evt  = EV_XOFF;
        else if (hits[IDX_ON_A]) evt  = EV_XON;
        else                     e_rx = 1'b1;
      end else if (!hold_q) begin
        if (hits[IDX_ON_A] || hits[IDX_OFF_A]) begin
          hold_n     = 1'b1;
          held_d_n   = rx_d;
          held_on_n  = hits[IDX_ON_A];
          held_off_n = hits[IDX_OFF_A];
        end else begin
          e_rx = 1'b1;
        end
      end else begin
        hold_n = 1'b0;
        if (held_off_q && hits[IDX_OFF_B])     evt = EV_XOFF;
        else if (held_on_q && hits[IDX_ON_B])  evt = EV_XON;
        else begin
          e_held = 1'b1;
          e_rx   = 1'b1;
        end
      end
    end
  end

  // next-state: pack emissions, oldest first, into two output slots
  always_comb begin
    cand_v    = {e_rx, e_held, pend_v_q};
    cand_d[0] = pend_d_q;
    cand_d[1] = held_d_q;
    cand_d[2] = rx_d;
    s_v       = '0;
    s_d       = '0;
    n_emit    = '0;
    for (int k = 0; k < NCAND; k++) begin
      if (cand_v[k] && (n_emit != 2'd2)) begin
        s_v[n_emit[0]] = 1'b1;
        s_d[n_emit[0]] = cand_d[k];
        n_emit         = n_emit + 2'd1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      held_d_q   <= '0;
      held_on_q  <= 1'b0;
      held_off_q <= 1'b0;
      fwd_v_q    <= 1'b0;
      fwd_d_q    <= '0;
      pend_v_q   <= 1'b0;
      pend_d_q   <= '0;
    end else begin
      hold_q     <= hold_n;
      held_on_q  <= held_on_n;
      held_off_q <= held_off_n;
      fwd_v_q    <= s_v[0];
      pend_v_q   <= s_v[1];
      if (hold_n && !hold_q) held_d_q <= held_d_n;
      if (s_v[0])            fwd_d_q  <= s_d[0];
      if (s_v[1])            pend_d_q <= s_d[1];
    end
  end

  assign fwd_v = fwd_v_q;
  assign fwd_d = fwd_d_q;

  // R5
  pend_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v_q |=> !pend_v_q);

  // R2
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != EV_NONE) |=> !fwd_v_q);
endmodule

// File: rtl/xfc_txgate.sv
module xfc_txgate
  import xfc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    flag_en,
  input  logic    rx_irq_en,
  input  logic    tx_busy,
  input  fc_evt_e evt,
  output logic    tx_allow,
  output logic    flag,
  output logic    irq
);
  logic susp_q, susp_n, flag_q, flag_n;

  always_comb begin
    susp_n = susp_q;
    flag_n = flag_q;
    if (!en) begin
      susp_n = 1'b0;
      flag_n = 1'b0;
    end else if (evt == EV_XOFF) begin
      susp_n = 1'b1;
      if (flag_en) flag_n = 1'b1;
    end else if (evt == EV_XON) begin
      susp_n = 1'b0;
      flag_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      susp_q <= susp_n;
      flag_q <= flag_n;
    end
  end

  assign tx_allow = !susp_q || tx_busy;
  assign flag     = flag_q;
  assign irq      = flag_q && rx_irq_en;

  // R7
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(flag_en) && ($past(evt) == EV_XOFF)));

  // R9
  off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!susp_q && !flag_q));

  // R2
  susp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> ($past(evt) == EV_XOFF));
endmodule

// File: rtl/xfc_top.sv
module xfc_top
  import xfc_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CHAR_W-1:0] cfg_wdata,
  input  logic              fc_en,
  input  logic              pair_mode,
  input  logic              flag_en,
  input  logic              rx_irq_en,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              tx_busy,
  output logic              fwd_valid,
  output logic [CHAR_W-1:0] fwd_data,
  output logic              tx_allow,
  output logic              fc_flag,
  output logic              irq
);
  logic [1:0]                  rst_pipe;
  logic                        rst_sync_n;
  logic [NREF-1:0][CHAR_W-1:0] refs;
  logic [NREF-1:0]             hits;
  fc_evt_e                     evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  xfc_chregs #(.CW(CHAR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .refs(refs));

  xfc_cmp #(.CW(CHAR_W)) u_cmp (.ch(rx_data), .refs(refs), .hits(hits));

  xfc_seq #(.CW(CHAR_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .en(fc_en), .pair(pair_mode),
    .rx_v(rx_valid), .rx_d(rx_data), .hits(hits),
    .fwd_v(fwd_valid), .fwd_d(fwd_data), .evt(evt));

  xfc_txgate u_gate (
    .clk(clk), .rst_n(rst_sync_n), .en(fc_en), .flag_en(flag_en),
    .rx_irq_en(rx_irq_en), .tx_busy(tx_busy), .evt(evt),
    .tx_allow(tx_allow), .flag(fc_flag), .irq(irq));

  // R3 (strobe spacing assumed by the two-slot release)
  rx_gap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_valid |=> !rx_valid);
endmodule

// File: tb/xfc_top_bench.sv
module xfc_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_wdata;
  logic       fc_en, pair_mode, flag_en, rx_irq_en, rx_valid, tx_busy;
  logic [7:0] rx_data;
  logic       fwd_valid, tx_allow, fc_flag, irq;
  logic [7:0] fwd_data;

  int  vec = 0;
  int  bad = 0;
  bit  done = 1'b0;
  logic       g0v, g1v;
  logic [7:0] g0d, g1d;

  always #2 clk = ~clk;

  xfc_top u_xfc_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fc_en(fc_en), .pair_mode(pair_mode),
    .flag_en(flag_en), .rx_irq_en(rx_irq_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_busy(tx_busy), .fwd_valid(fwd_valid),
    .fwd_data(fwd_data), .tx_allow(tx_allow), .fc_flag(fc_flag), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] ch);
    @(negedge clk); rx_valid = 1'b1; rx_data = ch;
    @(negedge clk); rx_valid = 1'b0; g0v = fwd_valid; g0d = fwd_data;
    @(negedge clk); g1v = fwd_valid; g1d = fwd_data;
  endtask

  task automatic t_reset;
    chk("R1 reset fwd_valid", 32'(fwd_valid), 0);
    chk("R1 reset tx_allow", 32'(tx_allow), 1);
    chk("R1 reset fc_flag", 32'(fc_flag), 0);
    chk("R8 reset irq", 32'(irq), 0);
  endtask

  task automatic t_regs_zero;
    send(8'h00);
    chk("R1 zero code dropped", 32'(g0v), 0);
    chk("R1 zero code halts", 32'(tx_allow), 0);
    chk("R8 irq with flag", 32'(irq), 1);
    @(negedge clk); fc_en = 1'b0;
    @(negedge clk);
    chk("R9 disable releases", 32'(tx_allow), 1);
    chk("R9 disable clears flag", 32'(fc_flag), 0);
    fc_en = 1'b1;
  endtask

  task automatic t_single;
    send(8'h41);
    chk("R3 pass valid", 32'(g0v), 1);
    chk("R3 pass data", 32'(g0d), 32'h41);
    chk("R3 one cycle", 32'(g1v), 0);
    send(8'h13);
    chk("R2 halt dropped", 32'(g0v), 0);
    chk("R2 halt suspends", 32'(tx_allow), 0);
    chk("R7 flag set", 32'(fc_flag), 1);
    send(8'h55);
    chk("R3 pass while halted", 32'(g0d), 32'h55);
    chk("R3 pass while halted valid", 32'(g0v), 1);
    send(8'h11);
    chk("R2 resume dropped", 32'(g0v), 0);
    chk("R2 resume releases", 32'(tx_allow), 1);
    chk("R7 flag cleared", 32'(fc_flag), 0);
    send(8'h11);
    chk("R10 idle resume dropped", 32'(g0v), 0);
    chk("R10 idle resume allow", 32'(tx_allow), 1);
  endtask

  task automatic t_busy;
    tx_busy = 1'b1;
    send(8'h13);
    chk("R6 busy keeps allow", 32'(tx_allow), 1);
    @(negedge clk); tx_busy = 1'b0; #1;
    chk("R6 allow drops at idle", 32'(tx_allow), 0);
    send(8'h11);
    chk("R6 resumed", 32'(tx_allow), 1);
  endtask

  task automatic t_flag_mask;
    flag_en = 1'b0;
    send(8'h13);
    chk("R7 masked halt suspends", 32'(tx_allow), 0);
    chk("R7 masked flag", 32'(fc_flag), 0);
    chk("R8 masked irq", 32'(irq), 0);
    send(8'h11);
    flag_en = 1'b1;
  endtask

  task automatic t_irq;
    rx_irq_en = 1'b0;
    send(8'h13);
    chk("R8 flag set", 32'(fc_flag), 1);
    chk("R8 irq gated", 32'(irq), 0);
    @(negedge clk); rx_irq_en = 1'b1; #1;
    chk("R8 irq follows enable", 32'(irq), 1);
    send(8'h11);
    chk("R8 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_pair;
    pair_mode = 1'b1;
    send(8'h13);
    chk("R4 first held", 32'(g0v | g1v), 0);
    chk("R4 not yet halted", 32'(tx_allow), 1);
    send(8'h14);
    chk("R4 second dropped", 32'(g0v | g1v), 0);
    chk("R4 pair halts", 32'(tx_allow), 0);
    send(8'h11);
    send(8'h12);
    chk("R4 pair resume dropped", 32'(g0v | g1v), 0);
    chk("R4 pair resumes", 32'(tx_allow), 1);
  endtask

  task automatic t_pair_miss;
    send(8'h13);
    send(8'h99);
    chk("R5 held first", 32'(g0d), 32'h13);
    chk("R5 held valid", 32'(g0v), 1);
    chk("R5 second next", 32'(g1d), 32'h99);
    chk("R5 second valid", 32'(g1v), 1);
    send(8'h11);
    send(8'h14);
    chk("R5 cross pair first", 32'(g0d), 32'h11);
    chk("R5 cross pair second", 32'(g1d), 32'h14);
    chk("R5 cross pair no halt", 32'(tx_allow), 1);
  endtask

  task automatic t_tie;
    pair_mode = 1'b0;
    cfg_write(2'd2, 8'h11);
    send(8'h11);
    chk("R2 tie halt wins", 32'(tx_allow), 0);
    cfg_write(2'd2, 8'h13);
    send(8'h11);
    chk("R2 resume after tie", 32'(tx_allow), 1);
  endtask

  task automatic t_disable;
    pair_mode = 1'b1;
    send(8'h13);
    @(negedge clk); fc_en = 1'b0;
    @(negedge clk);
    chk("R9 flush valid", 32'(fwd_valid), 1);
    chk("R9 flush data", 32'(fwd_data), 32'h13);
    @(negedge clk);
    chk("R9 flush once", 32'(fwd_valid), 0);
    send(8'h13);
    chk("R9 disabled passes", 32'(g0d), 32'h13);
    chk("R9 disabled no halt", 32'(tx_allow), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    fc_en = 1'b0; pair_mode = 1'b0; flag_en = 1'b0; rx_irq_en = 1'b0;
    rx_valid = 1'b0; rx_data = '0; tx_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    fc_en = 1'b1; flag_en = 1'b1; rx_irq_en = 1'b1;
    t_regs_zero();
    cfg_write(2'd0, 8'h11);
    cfg_write(2'd1, 8'h12);
    cfg_write(2'd2, 8'h13);
    cfg_write(2'd3, 8'h14);
    t_single();
    t_busy();
    t_flag_mask();
    t_irq();
    t_pair();
    t_pair_miss();
    t_tie();
    t_disable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule